// File: doc/BRIEF.md
# Processor Reset and Power-Up Sequencer

This block owns the architectural register state of a small 8-bit processor core: the accumulator A, the index registers X and Y, the stack pointer S, the status byte P and the 16-bit program counter. It tells a cold power-up apart from a warm reset and applies the correct initial values for each. It then runs a short start-up micro-sequence. First come three stack "push" cycles, which put stack addresses on the bus as reads with writes blocked and lower S once per cycle. Then come two reads of the start vector, which load the program counter. When the sequence is done, a ready output is raised.

A cold start is driven by the active-low power-on input. It forces A, X and Y to zero, P to 0x34 and S to 0x00, so the three pushes leave S at 0xFD. A warm reset comes from the active-low reset pin. It keeps A, X and Y, sets the interrupt-disable bit of P, and leaves S three lower than before. The block also drives clear strobes for the companion audio register file. A cold start clears the channel-enable register, the frame-mode register and the sixteen voice registers. A warm reset clears only the channel-enable register.

While the sequencer is ready, the execution core updates the registers through a simple write port. No write is ever driven to memory by this block, so RAM contents are not touched.

Top module: `reset_seq`

## Requirements
- R1: On a cold start (por_n low at a clock edge), A, X and Y become 0x00 and P becomes 0x34. After the following start-up sequence, S reads 0xFD.
- R2: After a clock edge with por_n low, snd_enable_clr, snd_frame_clr and snd_voice_clr are all 1.
- R3: While rst_pin_n is low and por_n is high, A, X and Y keep their values.
- R4: A warm reset followed by its start-up sequence leaves S equal to its value before reset minus 3, modulo 256.
- R5: After a clock edge with rst_pin_n low and por_n high, P equals its earlier value ORed with 0x04, with all other bits kept.
- R6: After a clock edge with rst_pin_n low and por_n high, snd_enable_clr is 1 and snd_frame_clr and snd_voice_clr are 0. With both reset inputs high, all three are 0.
- R7: The first three sequence cycles drive bus_addr = 0x0100 + S, with S taken before each decrement (S, S-1, S-2), with bus_rd = 1 and bus_wr = 0.
- R8: The next two cycles read 0xFFFC and then 0xFFFD. At the edge ending the 0xFFFD cycle, pc loads {byte read at 0xFFFD, byte read at 0xFFFC} and ready goes to 1.
- R9: While either reset input is low, ready and bus_rd stay 0. The first push cycle starts at the first clock edge that samples both inputs high.
- R10: When por_n and rst_pin_n are both low, the cold values of R1 and R2 apply (power-on has priority).
- R11: When ready is 1 and wr_en is 1, the register chosen by wr_sel (0 A, 1 X, 2 Y, 3 S, 4 P) loads wr_data at the next edge. When ready is 0, wr_en has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_pin_n | input | 1 | Warm reset pin, active low, synchronous |
| rd_data | input | 8 | Read data bus |
| wr_en | input | 1 | Register write strobe from the execution core |
| wr_sel | input | 3 | Register select for the write port |
| wr_data | input | 8 | Register write data |
| bus_addr | output | 16 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe (blocked during the sequence) |
| reg_a | output | 8 | Accumulator |
| reg_x | output | 8 | Index X |
| reg_y | output | 8 | Index Y |
| reg_s | output | 8 | Stack pointer |
| reg_p | output | 8 | Status byte |
| pc | output | 16 | Program counter |
| ready | output | 1 | Start-up sequence finished |
| snd_enable_clr | output | 1 | Clear the audio channel-enable register |
| snd_frame_clr | output | 1 | Clear the audio frame-mode register |
| snd_voice_clr | output | 1 | Clear the sixteen audio voice registers |

## Verification
The checker assumes that both reset inputs change only away from the clock edge. It also assumes that por_n is held low for at least one edge at the start, so every register holds a defined value before any property is enabled. The stimulus changes all inputs on the falling edge. It starts every run with a cold start, holds each reset input low for one to three edges, and drives the write port only while ready is high, except for directed attempts meant to show that writes are ignored during reset.

// File: rtl/reset_seq_pkg.sv
// Package: shared types and fixed constants of the reset sequencer.
// Assumes an 8-bit data path and a 16-bit address path.
package reset_seq_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_START = 3'd0,
        ST_PUSH  = 3'd1,
        ST_VLO   = 3'd2,
        ST_VHI   = 3'd3,
        ST_RUN   = 3'd4
    } seq_state_t;

    // Write port register codes
    localparam logic [2:0] SEL_A = 3'd0;
    localparam logic [2:0] SEL_X = 3'd1;
    localparam logic [2:0] SEL_Y = 3'd2;
    localparam logic [2:0] SEL_S = 3'd3;
    localparam logic [2:0] SEL_P = 3'd4;
endpackage

// File: rtl/reset_seq_fsm.sv
// Module: phase controller of the start-up sequence.
// Holds ST_START while either reset is low, then walks through PUSH_N
// push cycles, two vector reads, and parks in ST_RUN.
// Assumes synchronous active-low resets and PUSH_N >= 1.
module reset_seq_fsm
    import reset_seq_pkg::*;
#(
    parameter int PUSH_N = 3
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_pin_n,
    output seq_state_t state
);
    localparam int CNT_W = $clog2(PUSH_N + 1);

    logic [CNT_W-1:0] push_cnt;

    // Advance the phase and the push counter
    always_ff @(posedge clk) begin
        if (!por_n || !rst_pin_n) begin
            state    <= ST_START;
            push_cnt <= '0;
        end else begin
            case (state)
                ST_START: begin
                    state    <= ST_PUSH;
                    push_cnt <= '0;
                end
                ST_PUSH: begin
                    if (push_cnt == CNT_W'(PUSH_N - 1)) begin
                        state <= ST_VLO;
                    end
                    push_cnt <= push_cnt + 1'b1;
                end
                ST_VLO:  state <= ST_VHI;
                ST_VHI:  state <= ST_RUN;
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/reset_seq_regs.sv
// Module: architectural register file (A, X, Y, S, P, PC).
// Applies cold values on power-on, sets the interrupt mask on a warm
// reset, lowers S once per push cycle, assembles PC from the vector
// bytes and accepts core writes only in ST_RUN.
// Assumes the phase input comes from reset_seq_fsm.
module reset_seq_regs
    import reset_seq_pkg::*;
#(
    parameter logic [DATA_W-1:0] P_COLD   = 8'h34,
    parameter logic [DATA_W-1:0] S_COLD   = 8'h00,
    parameter logic [DATA_W-1:0] IRQ_MASK = 8'h04
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_pin_n,
    input  seq_state_t        state,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] reg_a,
    output logic [DATA_W-1:0] reg_x,
    output logic [DATA_W-1:0] reg_y,
    output logic [DATA_W-1:0] reg_s,
    output logic [DATA_W-1:0] reg_p,
    output logic [ADDR_W-1:0] pc
);
    logic [DATA_W-1:0] vec_lo;
    logic              core_wr;

    // A core write is honoured only once the sequence has finished
    always_comb core_wr = wr_en && (state == ST_RUN);

    // Data registers: cold clear, held on warm reset, else core writes
    always_ff @(posedge clk) begin
        if (!por_n) begin
            reg_a <= '0;
            reg_x <= '0;
            reg_y <= '0;
        end else if (rst_pin_n && core_wr) begin
            case (wr_sel)
                SEL_A:   reg_a <= wr_data;
                SEL_X:   reg_x <= wr_data;
                SEL_Y:   reg_y <= wr_data;
                default: ;
            endcase
        end
    end

    // Stack pointer: cold value, one decrement per masked push
    always_ff @(posedge clk) begin
        if (!por_n) begin
            reg_s <= S_COLD;
        end else if (rst_pin_n) begin
            if (state == ST_PUSH) begin
                reg_s <= reg_s - 1'b1;
            end else if (core_wr && wr_sel == SEL_S) begin
                reg_s <= wr_data;
            end
        end
    end

    // Status byte: cold value, mask bit forced on warm reset
    always_ff @(posedge clk) begin
        if (!por_n) begin
            reg_p <= P_COLD;
        end else if (!rst_pin_n) begin
            reg_p <= reg_p | IRQ_MASK;
        end else if (core_wr && wr_sel == SEL_P) begin
            reg_p <= wr_data;
        end
    end

    // Program counter: assembled from the two vector bytes
    always_ff @(posedge clk) begin
        if (!por_n) begin
            vec_lo <= '0;
            pc     <= '0;
        end else if (rst_pin_n) begin
            if (state == ST_VLO) begin
                vec_lo <= rd_data;
            end
            if (state == ST_VHI) begin
                pc <= {rd_data, vec_lo};
            end
        end
    end
endmodule

// File: rtl/reset_seq_bus.sv
// Module: bus address and strobe generator for the sequence.
// Push cycles address the stack page at the current S and request a
// write that is blocked until ST_RUN; vector cycles read the vector pair.
// Assumes S is the live stack pointer from reset_seq_regs.
module reset_seq_bus
    import reset_seq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] STACK_PAGE = 16'h0100,
    parameter logic [ADDR_W-1:0] VEC_ADDR   = 16'hFFFC
) (
    input  seq_state_t        state,
    input  logic [DATA_W-1:0] reg_s,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr
);
    logic wr_req;
    logic wr_block;

    // Address and strobe selection per phase
    always_comb begin
        bus_addr = '0;
        bus_rd   = 1'b0;
        wr_req   = 1'b0;
        case (state)
            ST_PUSH: begin
                bus_addr = STACK_PAGE | {{(ADDR_W-DATA_W){1'b0}}, reg_s};
                bus_rd   = 1'b1;
                wr_req   = 1'b1;
            end
            ST_VLO: begin
                bus_addr = VEC_ADDR;
                bus_rd   = 1'b1;
            end
            ST_VHI: begin
                bus_addr = VEC_ADDR + 1'b1;
                bus_rd   = 1'b1;
            end
            default: ;
        endcase
    end

    // Writes are blocked for the whole start-up sequence
    always_comb wr_block = (state != ST_RUN);
    always_comb bus_wr   = wr_req && !wr_block;
endmodule

// File: rtl/reset_seq_snd.sv
// Module: clear strobes for the audio register file.
// Cold start clears enables, frame mode and voices; a warm reset clears
// only the enables. Strobes are registered one edge after the reset input.
module reset_seq_snd (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin_n,
    output logic snd_enable_clr,
    output logic snd_frame_clr,
    output logic snd_voice_clr
);
    // Register the strobes from the two reset inputs
    always_ff @(posedge clk) begin
        if (!por_n) begin
            snd_enable_clr <= 1'b1;
            snd_frame_clr  <= 1'b1;
            snd_voice_clr  <= 1'b1;
        end else begin
            snd_enable_clr <= !rst_pin_n;
            snd_frame_clr  <= 1'b0;
            snd_voice_clr  <= 1'b0;
        end
    end
endmodule

// File: rtl/reset_seq.sv
// Module: top of the reset sequencer.
// Ties the phase controller, register file, bus generator and audio
// strobes together. Assumes por_n is pulsed low at least one edge at start.
module reset_seq
    import reset_seq_pkg::*;
#(
    parameter int                 PUSH_N     = 3,
    parameter logic [7:0]         P_COLD     = 8'h34,
    parameter logic [7:0]         S_COLD     = 8'h00,
    parameter logic [7:0]         IRQ_MASK   = 8'h04,
    parameter logic [15:0]        STACK_PAGE = 16'h0100,
    parameter logic [15:0]        VEC_ADDR   = 16'hFFFC
) (
    input  logic        clk,
    input  logic        por_n,
    input  logic        rst_pin_n,
    input  logic [7:0]  rd_data,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_data,
    output logic [15:0] bus_addr,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [7:0]  reg_a,
    output logic [7:0]  reg_x,
    output logic [7:0]  reg_y,
    output logic [7:0]  reg_s,
    output logic [7:0]  reg_p,
    output logic [15:0] pc,
    output logic        ready,
    output logic        snd_enable_clr,
    output logic        snd_frame_clr,
    output logic        snd_voice_clr
);
    seq_state_t state;

    reset_seq_fsm #(.PUSH_N(PUSH_N)) u_fsm (
        .clk       (clk),
        .por_n     (por_n),
        .rst_pin_n (rst_pin_n),
        .state     (state)
    );

    reset_seq_regs #(
        .P_COLD   (P_COLD),
        .S_COLD   (S_COLD),
        .IRQ_MASK (IRQ_MASK)
    ) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .rst_pin_n (rst_pin_n),
        .state     (state),
        .rd_data   (rd_data),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .reg_a     (reg_a),
        .reg_x     (reg_x),
        .reg_y     (reg_y),
        .reg_s     (reg_s),
        .reg_p     (reg_p),
        .pc        (pc)
    );

    reset_seq_bus #(
        .STACK_PAGE (STACK_PAGE),
        .VEC_ADDR   (VEC_ADDR)
    ) u_bus (
        .state    (state),
        .reg_s    (reg_s),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr)
    );

    reset_seq_snd u_snd (
        .clk            (clk),
        .por_n          (por_n),
        .rst_pin_n      (rst_pin_n),
        .snd_enable_clr (snd_enable_clr),
        .snd_frame_clr  (snd_frame_clr),
        .snd_voice_clr  (snd_voice_clr)
    );

    // Ready once the sequence has parked in the run phase
    always_comb ready = (state == ST_RUN);
endmodule

// File: rtl/reset_seq_chk.sv
// Module: property checker for reset_seq, attached by bind.
// Assumes por_n is low at the first clock edges of a run.
module reset_seq_chk (
    input logic        clk,
    input logic        por_n,
    input logic        rst_pin_n,
    input logic [15:0] bus_addr,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  reg_a,
    input logic [7:0]  reg_x,
    input logic [7:0]  reg_y,
    input logic [7:0]  reg_s,
    input logic [7:0]  reg_p,
    input logic        ready,
    input logic        snd_enable_clr,
    input logic        snd_frame_clr
);
    // First cycle after power-on release shows the cold values
    p_cold_values_r1: assert property (@(posedge clk) disable iff (!por_n)
        $rose(por_n) |-> (reg_a == 8'h00 && reg_x == 8'h00 &&
                          reg_y == 8'h00 && reg_p == 8'h34));

    // Warm reset leaves the data registers alone
    p_warm_keep_r3: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> (reg_a == $past(reg_a) && reg_x == $past(reg_x) &&
                        reg_y == $past(reg_y)));

    // Warm reset sets the mask bit and keeps the rest of P
    p_warm_mask_r5: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> (reg_p == ($past(reg_p) | 8'h04)));

    // Warm reset clears channel enables only
    p_warm_snd_r6: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> (snd_enable_clr && !snd_frame_clr));

    // Stack page reads track S and never write
    p_push_read_r7: assert property (@(posedge clk) disable iff (!por_n)
        (bus_rd && bus_addr[15:8] == 8'h01) |-> (bus_addr[7:0] == reg_s && !bus_wr));

    // Ready rises right after the high vector byte read
    p_ready_vec_r8: assert property (@(posedge clk) disable iff (!por_n)
        $rose(ready) |-> ($past(bus_rd) && $past(bus_addr) == 16'hFFFD));

    // Holding the pin keeps the sequencer idle
    p_hold_idle_r9: assert property (@(posedge clk) disable iff (!por_n)
        !rst_pin_n |=> (!ready && !bus_rd));
endmodule

bind reset_seq reset_seq_chk u_chk (
    .clk            (clk),
    .por_n          (por_n),
    .rst_pin_n      (rst_pin_n),
    .bus_addr       (bus_addr),
    .bus_rd         (bus_rd),
    .bus_wr         (bus_wr),
    .reg_a          (reg_a),
    .reg_x          (reg_x),
    .reg_y          (reg_y),
    .reg_s          (reg_s),
    .reg_p          (reg_p),
    .ready          (ready),
    .snd_enable_clr (snd_enable_clr),
    .snd_frame_clr  (snd_frame_clr)
);

// File: tb/reset_seq_bench.sv
// Bench: directed corners plus seeded random reset/write mixes.
// Inputs change and outputs are sampled on the falling edge.
module reset_seq_bench;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        rst_pin_n = 1'b1;
    logic [7:0]  rd_data = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] bus_addr;
    logic        bus_rd, bus_wr;
    logic [7:0]  reg_a, reg_x, reg_y, reg_s, reg_p;
    logic [15:0] pc;
    logic        ready, snd_enable_clr, snd_frame_clr, snd_voice_clr;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // Expected model
    logic [7:0] ea, ex, ey, es, ep;

    always #4 clk = ~clk;

    reset_seq u_reset_seq (
        .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .rd_data(rd_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .reg_a(reg_a), .reg_x(reg_x), .reg_y(reg_y), .reg_s(reg_s),
        .reg_p(reg_p), .pc(pc), .ready(ready),
        .snd_enable_clr(snd_enable_clr), .snd_frame_clr(snd_frame_clr),
        .snd_voice_clr(snd_voice_clr)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] warm_p(input logic [7:0] p);
        return p | 8'h04;
    endfunction

    function automatic logic [15:0] stack_addr(input logic [7:0] s);
        return 16'h0100 | {8'h00, s};
    endfunction

    task automatic check_data(input string req);
        check({req, " A"}, {8'h00, reg_a}, {8'h00, ea});
        check({req, " X"}, {8'h00, reg_x}, {8'h00, ex});
        check({req, " Y"}, {8'h00, reg_y}, {8'h00, ey});
    endtask

    // Run the start-up sequence; both resets must already be high
    task automatic run_seq(input logic [7:0] lo, input logic [7:0] hi);
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R9 R7 push addr", bus_addr, stack_addr(es));
            check("R7 push rd", {15'd0, bus_rd}, 16'd1);
            check("R7 push wr blocked", {15'd0, bus_wr}, 16'd0);
            check("R9 not ready", {15'd0, ready}, 16'd0);
            es = es - 8'd1;
        end
        tick();
        check("R8 vec lo addr", bus_addr, 16'hFFFC);
        check("R8 vec lo rd", {15'd0, bus_rd}, 16'd1);
        rd_data = lo;
        tick();
        check("R8 vec hi addr", bus_addr, 16'hFFFD);
        rd_data = hi;
        tick();
        rd_data = 8'h00;
        check("R8 ready", {15'd0, ready}, 16'd1);
        check("R8 pc", pc, {hi, lo});
        check("R4 S after pushes", {8'h00, reg_s}, {8'h00, es});
    endtask

    task automatic core_write(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0;
        case (sel)
            3'd0: ea = d;
            3'd1: ex = d;
            3'd2: ey = d;
            3'd3: es = d;
            3'd4: ep = d;
            default: ;
        endcase
        check_data("R11 write");
        check("R11 write S", {8'h00, reg_s}, {8'h00, es});
        check("R11 write P", {8'h00, reg_p}, {8'h00, ep});
    endtask

    task automatic cold(input logic pin);
        por_n = 1'b0; rst_pin_n = pin;
        tick();
        ea = 8'h00; ex = 8'h00; ey = 8'h00; es = 8'h00; ep = 8'h34;
        check_data(pin ? "R1 cold" : "R10 cold over pin");
        check(pin ? "R1 cold P" : "R10 cold P", {8'h00, reg_p}, 16'h0034);
        check("R2 enable clr", {15'd0, snd_enable_clr}, 16'd1);
        check("R2 frame clr", {15'd0, snd_frame_clr}, 16'd1);
        check("R2 voice clr", {15'd0, snd_voice_clr}, 16'd1);
        check("R9 idle in cold", {14'd0, ready, bus_rd}, 16'd0);
        por_n = 1'b1; rst_pin_n = 1'b1;
        run_seq(8'($urandom), 8'($urandom));
        check("R1 S after cold", {8'h00, reg_s}, 16'h00FD);
        check("R6 strobes idle", {13'd0, snd_enable_clr, snd_frame_clr, snd_voice_clr}, 16'd0);
    endtask

    task automatic warm(input int hold);
        logic [7:0] s0;
        s0 = es;
        rst_pin_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            wr_en = 1'b1; wr_sel = 3'd0; wr_data = ~ea;
            tick();
            wr_en = 1'b0;
            ep = warm_p(ep);
            check_data("R3 R11 warm keep");
            check("R5 P mask", {8'h00, reg_p}, {8'h00, ep});
            check("R9 held idle", {14'd0, ready, bus_rd}, 16'd0);
            check("R6 enable clr", {15'd0, snd_enable_clr}, 16'd1);
            check("R6 frame kept", {14'd0, snd_frame_clr, snd_voice_clr}, 16'd0);
            check("R4 S held", {8'h00, reg_s}, {8'h00, s0});
        end
        rst_pin_n = 1'b1;
        run_seq(8'($urandom), 8'($urandom));
        check("R4 S minus three", {8'h00, reg_s}, {8'h00, s0 - 8'd3});
        check_data("R3 after sequence");
    endtask

    initial begin
        void'($urandom(32'd2718));
        tick();
        tick();
        cold(1'b1);
        // Directed: warm reset near the stack wrap
        core_write(3'd3, 8'h01);
        core_write(3'd0, 8'hA5);
        core_write(3'd4, 8'h00);
        warm(2);
        // Directed: both resets low together
        cold(1'b0);
        for (int n = 0; n < 40; n++) begin
            for (int k = 0; k < 5; k++) begin
                core_write(3'(k), 8'($urandom));
            end
            case ($urandom % 3)
                0, 1: warm(1 + int'($urandom % 3));
                default: cold(1'($urandom));
            endcase
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule